// File: doc/BRIEF.md
# EEPROM Write Guard and Commit Sequencer

This block sits behind the serial front end of a small byte-wide nonvolatile memory. The front end shifts bits in and announces what it saw as single-cycle events in the system clock domain: an opcode has been decoded, the start address is complete, a whole data byte is complete, and chip select has risen together with the number of bits clocked during that select. From these events the block decides whether a write or a lock-code update may take effect. It then carries out the update during a self-timed busy window.

Three pieces of state live here: a write-enable latch, a 3-bit lock code that fences one region of the array against writes, and a one-page staging buffer. An accepted page write replays the staged bytes to the array through a strobe/address/data port, one byte per clock, at the start of the busy window. An accepted lock update changes the visible lock code at the end of the window. The busy length is a parameter in system clocks, so a bench can use a short value while silicon uses a multi-millisecond count.

Top module: `eeprom_wprot_ctrl`

## Requirements
- R1: After reset, busy_o is 0, lock_code_o is 0, no array strobe is issued, and the write-enable latch is clear, so a write sent without a prior enable does not start busy.
- R2: The enable opcode sets the latch only when chip select rises with a bit count of exactly 8. Any other count leaves the latch unchanged. The disable opcode clears the latch.
- R3: The latch is cleared when a busy window ends, whether it carried a page write or a lock update.
- R4: A page write commits only when chip select rises with a bit count of at least 32 that is a multiple of 8. A lock update commits only when the count is at least 16 and a multiple of 8. A rejected commit leaves the latch unchanged.
- R5: A transaction does not commit if wp_n_i is low at any cycle between its opcode and its chip-select rise. Driving wp_n_i low during a busy window does not stop the array strobes already scheduled.
- R6: Lock codes fence these address ranges: 0 nothing; 1 0x000-0x07F; 2 0x080-0x0FF; 3 0x100-0x17F; 4 0x180-0x1FF; 5 0x000-0x0FF; 6 0x000-0x00F; 7 0x1F0-0x1FF. A page write that touches any fenced byte is dropped as a whole, starts no busy window, and clears the latch.
- R7: Data bytes land at successive offsets inside the 16-byte page of the start address. The offset wraps from 15 to 0, so a later byte overwrites an earlier one at the same offset.
- R8: A lock update takes bits [2:0] of the last data byte in the transaction. lock_code_o keeps its old value until the busy window ends.
- R9: A committed transaction holds busy_o high for exactly BUSY_CYCLES clocks. A page write issues one arr_we_o pulse per distinct written offset, all inside that window.
- R10: While busy_o is high, every opcode event and chip-select rise is ignored. No latch change, lock change or new commit results from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_wren_i | input | 1 | Write-enable opcode decoded (pulse) |
| op_wrdi_i | input | 1 | Write-disable opcode decoded (pulse) |
| op_write_i | input | 1 | Page-write opcode decoded (pulse) |
| op_lock_i | input | 1 | Lock-update opcode decoded (pulse) |
| addr_vld_i | input | 1 | Start address complete (pulse) |
| addr_i | input | ADDR_W | Start address of a page write |
| byte_vld_i | input | 1 | Data byte complete (pulse) |
| byte_i | input | 8 | Data byte |
| cs_rise_i | input | 1 | Chip select went high (pulse) |
| bit_cnt_i | input | BITCNT_W | Bits clocked during the select that just ended |
| wp_n_i | input | 1 | Write-protect level, low blocks writes |
| busy_o | output | 1 | Self-timed update in progress |
| lock_code_o | output | 3 | Current lock code |
| arr_we_o | output | 1 | Array byte write strobe |
| arr_addr_o | output | ADDR_W | Array byte address |
| arr_data_o | output | 8 | Array byte data |

## Verification
A stale or wrongly set write-enable latch shows as busy_o rising, or failing to rise, on the clock after the chip-select rise of the next write. That makes latch errors visible within one transaction. A wrong page pointer or wrap shows in the arr_addr_o/arr_data_o pairs during the first sixteen cycles of the busy window. The bench compares its captured array image against a reference model after every write. A corrupted lock code appears either in lock_code_o at the end of a lock window or as a wrongly accepted or rejected write at the next commit. Random lock codes paired with random page writes cover the boundary addresses of every fenced region.

// File: rtl/ewp_pkg.sv
// Shared types for the write guard and commit sequencer.
package ewp_pkg;
    // Kind of transaction open between an opcode event and chip-select rise.
    typedef enum logic [1:0] {
        TX_NONE  = 2'd0,
        TX_WREN  = 2'd1,
        TX_WRITE = 2'd2,
        TX_LOCK  = 2'd3
    } txn_kind_e;

    localparam int LOCK_W = 3;
endpackage

// File: rtl/ewp_lock_map.sv
// Lock region decoder.
// Does: tells whether an address lies inside the region fenced by a lock code.
// Assumes: the array spans 2**ADDR_W bytes split into pages of 2**PAGE_W bytes.
module ewp_lock_map #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic [2:0]        code_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);
    localparam int SPAN = 1 << ADDR_W;
    localparam int QTR  = SPAN / 4;
    localparam int PG   = 1 << PAGE_W;

    logic [31:0] lo, hi, a32;
    logic        en;

    assign a32 = 32'(addr_i);

    // Pick the fenced range bounds for the current code.
    always_comb begin
        en = 1'b1;
        lo = '0;
        hi = '0;
        case (code_i)
            3'd1: begin lo = 32'(0);        hi = 32'(QTR - 1);     end
            3'd2: begin lo = 32'(QTR);      hi = 32'(2*QTR - 1);   end
            3'd3: begin lo = 32'(2*QTR);    hi = 32'(3*QTR - 1);   end
            3'd4: begin lo = 32'(3*QTR);    hi = 32'(SPAN - 1);    end
            3'd5: begin lo = 32'(0);        hi = 32'(2*QTR - 1);   end
            3'd6: begin lo = 32'(0);        hi = 32'(PG - 1);      end
            3'd7: begin lo = 32'(SPAN - PG); hi = 32'(SPAN - 1);   end
            default: en = 1'b0;
        endcase
    end

    assign locked_o = en && (a32 >= lo) && (a32 <= hi);
endmodule

// File: rtl/ewp_page_buf.sv
// Page staging buffer.
// Does: stores data bytes at a wrapping offset within one page and marks the offsets written.
// Assumes: load_i comes with the start offset before any push_i of the same transaction.
module ewp_page_buf #(
    parameter int PAGE_W = 4,
    localparam int PAGE_BYTES = 1 << PAGE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [PAGE_W-1:0]     off_i,
    input  logic                  push_i,
    input  logic [7:0]            data_i,
    input  logic [PAGE_W-1:0]     rd_idx_i,
    output logic [PAGE_BYTES-1:0] mask_o,
    output logic [7:0]            rd_data_o
);
    logic [7:0]        mem_q [PAGE_BYTES];
    logic [PAGE_W-1:0] ptr_q;

    // Track the write pointer and the written-offset mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            mask_o <= '0;
        end else if (load_i) begin
            ptr_q  <= off_i;
            mask_o <= '0;
        end else if (push_i) begin
            ptr_q         <= ptr_q + 1'b1;
            mask_o[ptr_q] <= 1'b1;
        end
    end

    // Store the byte at the current pointer; a wrapped pointer overwrites.
    always_ff @(posedge clk) begin
        if (push_i && !load_i) begin
            mem_q[ptr_q] <= data_i;
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/ewp_busy_timer.sv
// Self-timed busy window.
// Does: holds busy for exactly BUSY_CYCLES clocks after a start pulse and exposes the elapsed count.
// Assumes: start_i is only raised while idle.
module ewp_busy_timer #(
    parameter int BUSY_CYCLES = 500000,
    localparam int CNT_W = $clog2(BUSY_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] elapsed_o,
    output logic             last_o
);
    assign last_o = busy_o && (elapsed_o == CNT_W'(BUSY_CYCLES - 1));

    // Run the window counter from start to its final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o    <= 1'b0;
            elapsed_o <= '0;
        end else if (start_i && !busy_o) begin
            busy_o    <= 1'b1;
            elapsed_o <= '0;
        end else if (busy_o) begin
            if (last_o) begin
                busy_o    <= 1'b0;
                elapsed_o <= '0;
            end else begin
                elapsed_o <= elapsed_o + 1'b1;
            end
        end
    end

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o) else $error("start while busy"); // R10
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (32'(elapsed_o) < BUSY_CYCLES)) else $error("window overrun"); // R9
endmodule

// File: rtl/eeprom_wprot_ctrl.sv
// Write guard and commit sequencer.
// Does: qualifies page writes and lock updates against the enable latch, the write-protect
//       level, the lock region and the chip-select bit count; then runs the busy window,
//       replays the page to the array and applies the new lock code.
// Assumes: every input event is a single-cycle pulse from the serial front end, and
//          BUSY_CYCLES is larger than the page size.
module eeprom_wprot_ctrl
    import ewp_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int PAGE_W      = 4,
    parameter int BITCNT_W    = 16,
    parameter int BUSY_CYCLES = 500000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_wren_i,
    input  logic                op_wrdi_i,
    input  logic                op_write_i,
    input  logic                op_lock_i,
    input  logic                addr_vld_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                byte_vld_i,
    input  logic [7:0]          byte_i,
    input  logic                cs_rise_i,
    input  logic [BITCNT_W-1:0] bit_cnt_i,
    input  logic                wp_n_i,
    output logic                busy_o,
    output logic [2:0]          lock_code_o,
    output logic                arr_we_o,
    output logic [ADDR_W-1:0]   arr_addr_o,
    output logic [7:0]          arr_data_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PIDX_W     = ADDR_W - PAGE_W;
    localparam int CNT_W      = $clog2(BUSY_CYCLES);

    txn_kind_e              kind_q;
    logic                   have_addr_q, have_data_q, wp_drop_q;
    logic                   wel_q, is_array_q;
    logic [PIDX_W-1:0]      page_q;
    logic [LOCK_W-1:0]      lock_pend_q, lock_q;
    logic                   op_accept, aligned, wp_ok;
    logic                   wr_commit, lk_commit, wr_start, wr_reject, start;
    logic                   any_locked, busy_last, in_window;
    logic [PAGE_BYTES-1:0]  mask, locked_vec;
    logic [PAGE_W-1:0]      slot;
    logic [CNT_W-1:0]       elapsed;
    logic [7:0]             rd_data;
    logic                   strobe_locked;

    assign op_accept = !busy_o && (op_wren_i || op_wrdi_i || op_write_i || op_lock_i);
    assign aligned   = (bit_cnt_i[2:0] == 3'd0);
    assign wp_ok     = wp_n_i && !wp_drop_q;

    assign wr_commit = cs_rise_i && !busy_o && (kind_q == TX_WRITE) && have_addr_q
                    && have_data_q && (bit_cnt_i >= BITCNT_W'(32)) && aligned && wel_q && wp_ok;
    assign lk_commit = cs_rise_i && !busy_o && (kind_q == TX_LOCK) && have_data_q
                    && (bit_cnt_i >= BITCNT_W'(16)) && aligned && wel_q && wp_ok;
    assign any_locked = |(mask & locked_vec);
    assign wr_start   = wr_commit && !any_locked;
    assign wr_reject  = wr_commit && any_locked;
    assign start      = wr_start || lk_commit;

    // Open, track and close the transaction between opcode and chip-select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q      <= TX_NONE;
            have_addr_q <= 1'b0;
            have_data_q <= 1'b0;
            wp_drop_q   <= 1'b0;
            page_q      <= '0;
            lock_pend_q <= '0;
        end else if (cs_rise_i) begin
            kind_q      <= TX_NONE;
            have_addr_q <= 1'b0;
            have_data_q <= 1'b0;
            wp_drop_q   <= 1'b0;
        end else if (op_accept) begin
            kind_q      <= op_wren_i  ? TX_WREN  :
                           op_write_i ? TX_WRITE :
                           op_lock_i  ? TX_LOCK  : TX_NONE;
            have_addr_q <= 1'b0;
            have_data_q <= 1'b0;
            wp_drop_q   <= !wp_n_i;
        end else begin
            if (kind_q != TX_NONE && !wp_n_i) begin
                wp_drop_q <= 1'b1;
            end
            if (addr_vld_i && kind_q == TX_WRITE) begin
                have_addr_q <= 1'b1;
                page_q      <= addr_i[ADDR_W-1:PAGE_W];
            end
            if (byte_vld_i && ((kind_q == TX_WRITE && have_addr_q) || kind_q == TX_LOCK)) begin
                have_data_q <= 1'b1;
            end
            if (byte_vld_i && kind_q == TX_LOCK) begin
                lock_pend_q <= byte_i[LOCK_W-1:0];
            end
        end
    end

    // Write-enable latch: set by a clean enable, cleared by disable, rejection or completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
        end else if (busy_last || wr_reject) begin
            wel_q <= 1'b0;
        end else if (op_accept && op_wrdi_i) begin
            wel_q <= 1'b0;
        end else if (cs_rise_i && !busy_o && kind_q == TX_WREN && bit_cnt_i == BITCNT_W'(8)) begin
            wel_q <= 1'b1;
        end
    end

    // Remember the window type and apply a pending lock code at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_array_q <= 1'b0;
            lock_q     <= '0;
        end else begin
            if (start) begin
                is_array_q <= wr_start;
            end
            if (busy_last && !is_array_q) begin
                lock_q <= lock_pend_q;
            end
        end
    end

    ewp_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (addr_vld_i && kind_q == TX_WRITE && !cs_rise_i),
        .off_i     (addr_i[PAGE_W-1:0]),
        .push_i    (byte_vld_i && kind_q == TX_WRITE && have_addr_q && !cs_rise_i),
        .data_i    (byte_i),
        .rd_idx_i  (slot),
        .mask_o    (mask),
        .rd_data_o (rd_data)
    );

    ewp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .busy_o    (busy_o),
        .elapsed_o (elapsed),
        .last_o    (busy_last)
    );

    // One lock decoder per page offset to screen the whole staged page.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_screen
        ewp_lock_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_map (
            .code_i   (lock_q),
            .addr_i   ({page_q, PAGE_W'(g)}),
            .locked_o (locked_vec[g])
        );
    end

    ewp_lock_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_strobe_map (
        .code_i   (lock_q),
        .addr_i   (arr_addr_o),
        .locked_o (strobe_locked)
    );

    assign slot        = elapsed[PAGE_W-1:0];
    assign in_window   = (32'(elapsed) < PAGE_BYTES);
    assign arr_we_o    = busy_o && is_array_q && in_window && mask[slot];
    assign arr_addr_o  = {page_q, slot};
    assign arr_data_o  = rd_data;
    assign lock_code_o = lock_q;

    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> busy_o) else $error("strobe outside window"); // R9
    AST_WE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> !strobe_locked) else $error("strobe into fenced region"); // R6
    AST_BUSY_WP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(wp_n_i)) else $error("commit with protect low"); // R5
    AST_BUSY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(cs_rise_i) && $past(bit_cnt_i[2:0]) == 3'd0))
        else $error("commit off byte boundary"); // R4
    AST_WEL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !wel_q) else $error("latch survived window"); // R3
    AST_LOCK_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_code_o) |-> $fell(busy_o)) else $error("lock code moved mid-window"); // R8
endmodule

// File: tb/tb_eeprom_wprot_ctrl.sv
`timescale 1ns/1ps
module tb_eeprom_wprot_ctrl;
    localparam int ADDR_W = 9, PAGE_W = 4, BCW = 16, BUSY = 40;

    logic clk = 0, rst_n = 0;
    logic op_wren = 0, op_wrdi = 0, op_write = 0, op_lock = 0;
    logic addr_vld = 0, byte_vld = 0, cs_rise = 0, wp_n = 1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] bdat = '0;
    logic [BCW-1:0] bit_cnt = '0;
    logic busy_o, arr_we_o;
    logic [2:0] lock_code_o;
    logic [ADDR_W-1:0] arr_addr_o;
    logic [7:0] arr_data_o;

    int nchk = 0, nfail = 0, we_total = 0;
    bit done = 0;
    logic [7:0] cap [512];
    logic [7:0] mem_m [512];
    logic [7:0] dbuf [32];
    bit wel_m = 0;
    logic [2:0] lock_m = 0;

    always #4 clk = ~clk;

    eeprom_wprot_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BITCNT_W(BCW), .BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .op_wren_i(op_wren), .op_wrdi_i(op_wrdi),
        .op_write_i(op_write), .op_lock_i(op_lock), .addr_vld_i(addr_vld), .addr_i(addr),
        .byte_vld_i(byte_vld), .byte_i(bdat), .cs_rise_i(cs_rise), .bit_cnt_i(bit_cnt),
        .wp_n_i(wp_n), .busy_o(busy_o), .lock_code_o(lock_code_o), .arr_we_o(arr_we_o),
        .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o));

    // Capture the array image from the strobe port.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) cap[i] <= 8'h00;
        end else if (arr_we_o) begin
            cap[arr_addr_o] <= arr_data_o;
            we_total <= we_total + 1;
        end
    end

    function automatic bit fenced(input logic [2:0] c, input int a);
        case (c)
            3'd1: return a <= 127;
            3'd2: return a >= 128 && a <= 255;
            3'd3: return a >= 256 && a <= 383;
            3'd4: return a >= 384;
            3'd5: return a <= 255;
            3'd6: return a <= 15;
            3'd7: return a >= 496;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic op(input int which);
        case (which)
            0: op_wren = 1;
            1: op_wrdi = 1;
            2: op_write = 1;
            default: op_lock = 1;
        endcase
        @(negedge clk);
        op_wren = 0; op_wrdi = 0; op_write = 0; op_lock = 0;
    endtask

    task automatic addr_pulse(input logic [8:0] a);
        addr_vld = 1; addr = a;
        @(negedge clk);
        addr_vld = 0;
    endtask

    task automatic byte_pulse(input logic [7:0] b);
        byte_vld = 1; bdat = b;
        @(negedge clk);
        byte_vld = 0;
    endtask

    task automatic cs_end(input int bits, output bit b);
        cs_rise = 1; bit_cnt = BCW'(bits);
        @(negedge clk);
        cs_rise = 0;
        b = busy_o;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy_o) begin
            cyc++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        for (int i = 0; i < 512; i++) if (cap[i] !== mem_m[i]) bad++;
        chk(req, "array image mismatches", bad, 0);
    endtask

    task automatic do_wren(input int bits);
        bit b;
        op(0);
        cs_end(bits, b);
        if (bits == 8) wel_m = 1;
        chk("R2", "enable starts no window", int'(b), 0);
    endtask

    task automatic do_wrdi();
        bit b;
        op(1);
        cs_end(8, b);
        wel_m = 0;
    endtask

    // wpm: 0 none, 1 protect pulse mid-transaction, 2 protect held low.
    // busy_mode: 0 plain, 1 protect low during window, 2 send ops during window.
    task automatic do_write(input logic [8:0] a, input int n, input int bits,
                            input int wpm, input int busy_mode, input string req);
        bit b, commit, locked, exp_busy;
        int we0, cyc, k;
        logic [2:0] lk0;
        we0 = we_total;
        lk0 = lock_code_o;
        if (wpm == 2) wp_n = 0;
        op(2);
        addr_pulse(a);
        for (int i = 0; i < n; i++) begin
            byte_pulse(dbuf[i]);
            if (wpm == 1 && i == 0) begin wp_n = 0; @(negedge clk); wp_n = 1; end
        end
        cs_end(bits, b);
        wp_n = 1;
        commit = wel_m && n > 0 && bits >= 32 && bits % 8 == 0 && wpm == 0;
        locked = 0;
        k = (n < 16) ? n : 16;
        for (int i = 0; i < k; i++)
            if (fenced(lock_m, {a[8:4], 4'(a[3:0] + i)})) locked = 1;
        exp_busy = commit && !locked;
        if (commit) wel_m = 0;
        chk(req, "window started at chip-select rise", int'(b), int'(exp_busy));
        if (exp_busy) begin
            for (int i = 0; i < n; i++) mem_m[{a[8:4], 4'(a[3:0] + i)}] = dbuf[i];
        end
        if (b) begin
            if (busy_mode == 1) wp_n = 0;
            if (busy_mode == 2) begin
                bit x;
                op(0); cs_end(8, x);
                op(3); byte_pulse(8'h05); cs_end(16, x);
                op(2); addr_pulse(9'h000); byte_pulse(8'hAA); cs_end(32, x);
            end
            wait_idle(cyc);
            wp_n = 1;
            if (busy_mode == 0) chk("R9", "window length", cyc, BUSY);
            chk("R9", "strobe count", we_total - we0, exp_busy ? k : 0);
            if (busy_mode == 2) chk("R10", "lock code kept across window", int'(lock_code_o), int'(lk0));
        end else begin
            chk(req, "no strobe for dropped write", we_total - we0, 0);
        end
        cmp_mem(req);
    endtask

    task automatic do_lock(input int n, input int bits, input string req);
        bit b, commit;
        int cyc;
        logic [2:0] old;
        old = lock_code_o;
        op(3);
        for (int i = 0; i < n; i++) byte_pulse(dbuf[i]);
        cs_end(bits, b);
        commit = wel_m && n > 0 && bits >= 16 && bits % 8 == 0;
        chk(req, "lock window started", int'(b), int'(commit));
        chk("R8", "lock code unchanged at window start", int'(lock_code_o), int'(old));
        if (b) begin
            wait_idle(cyc);
            chk("R9", "lock window length", cyc, BUSY);
        end
        if (commit) begin
            wel_m = 0;
            lock_m = dbuf[n-1][2:0];
        end
        chk("R8", "lock code after window", int'(lock_code_o), int'(lock_m));
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
    endtask

    initial begin
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < 512; i++) mem_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy after reset", int'(busy_o), 0);
        chk("R1", "lock code after reset", int'(lock_code_o), 0);
        chk("R1", "strobes after reset", we_total, 0);
        fill(4); do_write(9'h020, 1, 32, 0, 0, "R1");
        // R2 clean enable then write; R3 latch consumed
        do_wren(8); fill(4); do_write(9'h010, 4, 56, 0, 0, "R2");
        fill(2); do_write(9'h030, 2, 40, 0, 0, "R3");
        do_wren(9); fill(2); do_write(9'h030, 2, 40, 0, 0, "R2");
        do_wren(8); do_wrdi(); fill(2); do_write(9'h030, 2, 40, 0, 0, "R2");
        // R4 alignment
        do_wren(8); fill(2); do_write(9'h050, 2, 36, 0, 0, "R4");
        do_lock(1, 12, "R4");
        fill(2); do_write(9'h050, 2, 40, 0, 0, "R4");
        // R5 protect pin
        do_wren(8); fill(3); do_write(9'h060, 3, 48, 2, 0, "R5");
        fill(3); do_write(9'h060, 3, 48, 1, 0, "R5");
        fill(3); do_write(9'h060, 3, 48, 0, 1, "R5");
        // R7 wrap inside page
        do_wren(8); fill(4); do_write(9'h03E, 4, 56, 0, 0, "R7");
        do_wren(8); fill(18); do_write(9'h140, 18, 168, 0, 0, "R7");
        // R8 last lock byte wins; R6 fenced writes
        do_wren(8); dbuf[0] = 8'h07; dbuf[1] = 8'hF1; dbuf[2] = 8'h02; do_lock(3, 32, "R8");
        do_wren(8); fill(2); do_write(9'h090, 2, 40, 0, 0, "R6");
        fill(2); do_write(9'h010, 2, 40, 0, 0, "R6");
        do_wren(8); fill(20); do_write(9'h070, 20, 184, 0, 0, "R6");
        do_wren(8); dbuf[0] = 8'h07; do_lock(1, 16, "R6");
        do_wren(8); fill(3); do_write(9'h1FD, 3, 48, 0, 0, "R6");
        do_wren(8); fill(3); do_write(9'h1E0, 3, 48, 0, 0, "R6");
        // R10 ops during window are ignored
        do_wren(8); fill(2); do_write(9'h0A0, 2, 40, 0, 2, "R10");
        fill(1); do_write(9'h0B0, 1, 32, 0, 0, "R10");
        // random mix
        for (int it = 0; it < 40; it++) begin
            do_wren(8);
            fill(3);
            do_lock(1 + int'($urandom % 3), 16 + 8 * int'($urandom % 3), "R6");
            for (int w = 0; w < 3; w++) begin
                int n, bits;
                if ($urandom % 10 < 8) do_wren(8);
                n = 1 + int'($urandom % 20);
                bits = 24 + 8 * n;
                if ($urandom % 10 == 0) bits = bits + 1 + int'($urandom % 7);
                fill(n);
                do_write(9'($urandom), n, bits, 0, 0, "R6");
            end
        end
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        done = 1;
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule